// File: doc/BRIEF.md
# Boot-Mode Program Address Decoder

This block decodes the program half of an 8-bit CPU cartridge bus. Out of reset it is in a startup mode. In that mode every access to the upper 32 KB window goes to an external boot source that does not look at the address, so that source can feed a loader to the CPU byte by byte. The first CPU write anywhere in the upper window ends startup mode. From then on the same window is served from a 128 KB program RAM. The RAM is split into sixteen 8 KB banks, and the bank for each 8 KB slot is chosen through a pair of registers.

A separate staging window at $6000-$7FFF maps any bank, in either mode. Software fills a bank there and then moves it into $C000-$FFFF, the only range that sample playback hardware can fetch from. The top slot $E000-$FFFF always holds the last bank, which carries the reset vector. Accesses to $5000 and $5001 produce a select strobe for a coprocessor register pair. The coprocessor reads R/W on its own.

Every enable is combinational from the bus and is gated by M2. Register updates are taken on the system clock, at the first edge that sees M2 high during a write. Only the low data lines that the bank registers need are wired to the block.

Top module: `prg_boot_decoder`

## Requirements
- R1: After reset the block is in startup mode, slots $8000, $A000, $C000 and the staging window hold bank 0, the slot index register is 0, and $E000-$FFFF holds bank 2**BANK_W-1 (15 by default).
- R2: In startup mode, any access to $8000-$FFFF with M2 high asserts boot_en and keeps ram_sel low.
- R3: In startup mode, a CPU write to any address in $8000-$FFFF clears startup mode. That write is not taken as a bank register write.
- R4: Once startup mode is clear, boot_en stays low until the next reset, and accesses to $8000-$FFFF assert ram_sel with ram_bank set to the bank of the addressed 8 KB slot.
- R5: Once startup mode is clear, a write to exactly $8000 loads the slot index from data bits 2:0. A write to exactly $8001 loads data bits BANK_W-1:0 into the slot the index names: 0 is $8000, 1 is $A000, 2 is $C000 and 4 is the staging window $6000.
- R6: A data write while the index is 3, 5, 6 or 7 changes no mapping, and $E000-$FFFF always reads as bank 2**BANK_W-1.
- R7: Accesses to $6000-$7FFF with M2 high assert ram_sel with the staging bank, in startup mode and after it.
- R8: cop_en is high for accesses to $5000 and $5001 (reads and writes) with M2 high, and low at every other address.
- R9: With M2 low, ram_sel, boot_en and cop_en are all low, and no register or mode change takes place. Whenever ram_sel is low, ram_bank is 0.
- R10: Once startup mode is clear, a write to $8000 or $8001 does not assert ram_sel, so the RAM is not written.
- R11: A register write takes effect at the first clock edge at which M2 is high and R/W is low. It is visible from the next access on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than M2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | BANK_W | Low CPU data lines D(BANK_W-1)..D0 |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_m2 | input | 1 | CPU M2 phase; bus valid while high |
| ram_sel | output | 1 | Program RAM chip enable, active high |
| ram_bank | output | BANK_W | Program RAM bank address lines (A16..A13) |
| boot_en | output | 1 | Boot source enable, active high |
| cop_en | output | 1 | Coprocessor register enable, active high |

## Verification
The bench targets the write that ends startup mode, in particular one aimed at $8001. A design that also took that write as a register update would leave $8000 mapped to the wrong bank. It also writes through the forbidden indexes 3 and 5-7. A loose index decode would corrupt the fixed top bank or alias onto the $8000-$C000 slots. It probes the edges of the coprocessor pair and of the staging window ($4FFF, $5002, $5FFF, $7FFF). A broad decode would raise cop_en or ram_sel there. It checks for RAM selects during register writes and with M2 low, where a decode missing that gating would corrupt RAM contents. It also drives writes with M2 held low, which a design that ignored M2 would still commit.

// File: rtl/prg_dec_pkg.sv
package prg_dec_pkg;

  localparam logic [15:0] REG_IDX_ADDR  = 16'h8000;
  localparam logic [15:0] REG_DATA_ADDR = 16'h8001;
  localparam logic [14:0] COP_PAIR_TAG  = 15'h2800;  // $5000/$5001 >> 1
  localparam logic [2:0]  STAGE_SLOT    = 3'd4;
  localparam logic [2:0]  STAGE_PAGE    = 3'b011;    // $6000-$7FFF
  localparam int          NUM_LOW_SLOTS = 3;         // $8000, $A000, $C000

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_COP,
    WIN_STAGE,
    WIN_BOOT,
    WIN_RAM,
    WIN_REG
  } win_e;

endpackage

// File: rtl/prg_bus_ctl.sv
module prg_bus_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_m2,
  input  logic cpu_rw,
  input  logic addr_hi,
  output logic wr_stb,
  output logic startup
);

  logic m2_q, m2_d;
  logic startup_q, startup_d;

  // one strobe per M2 high phase, on its first clock edge
  assign wr_stb = cpu_m2 & ~m2_q & ~cpu_rw;

  always_comb begin
    m2_d      = cpu_m2;
    startup_d = startup_q;
    if (wr_stb && addr_hi && startup_q) begin
      startup_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m2_q      <= 1'b0;
      startup_q <= 1'b1;
    end else begin
      m2_q      <= m2_d;
      startup_q <= startup_d;
    end
  end

  assign startup = startup_q;

endmodule

// File: rtl/prg_bank_file.sv
module prg_bank_file #(
  parameter int BANK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic                  startup,
  input  logic [15:0]           cpu_addr,
  input  logic [BANK_W-1:0]     cpu_data,
  output logic [4*BANK_W-1:0]   banks_o   // {stage, slot2, slot1, slot0}
);
  import prg_dec_pkg::*;

  logic          reg_wr;
  logic          idx_en, data_en;
  logic [2:0]    idx_q, idx_d;

  assign reg_wr  = wr_stb & ~startup;
  assign idx_en  = reg_wr & (cpu_addr == REG_IDX_ADDR);
  assign data_en = reg_wr & (cpu_addr == REG_DATA_ADDR);

  always_comb begin
    idx_d = idx_q;
    if (idx_en) idx_d = cpu_data[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LOW_SLOTS + 1; g++) begin : g_slot
      localparam logic [2:0] MY_IDX = (g == NUM_LOW_SLOTS) ? STAGE_SLOT : 3'(g);
      logic              slot_en;
      logic [BANK_W-1:0] slot_q, slot_d;

      assign slot_en = data_en & (idx_q == MY_IDX);

      always_comb begin
        slot_d = slot_q;
        if (slot_en) slot_d = cpu_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
      end

      assign banks_o[g*BANK_W +: BANK_W] = slot_q;
    end
  endgenerate

endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode #(
  parameter int BANK_W = 4
) (
  input  logic [15:0]         cpu_addr,
  input  logic                cpu_rw,
  input  logic                cpu_m2,
  input  logic                startup,
  input  logic [4*BANK_W-1:0] banks_i,
  output logic                ram_sel,
  output logic [BANK_W-1:0]   ram_bank,
  output logic                boot_en,
  output logic                cop_en
);
  import prg_dec_pkg::*;

  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  win_e              win;
  logic              reg_hit;
  logic [BANK_W-1:0] slot_bank;

  assign reg_hit = ~cpu_rw & (cpu_addr[15:1] == REG_IDX_ADDR[15:1]);

  always_comb begin
    win = WIN_NONE;
    if (cpu_addr[15:1] == COP_PAIR_TAG) begin
      win = WIN_COP;
    end else if (cpu_addr[15:13] == STAGE_PAGE) begin
      win = WIN_STAGE;
    end else if (cpu_addr[15]) begin
      if (startup)      win = WIN_BOOT;
      else if (reg_hit) win = WIN_REG;
      else              win = WIN_RAM;
    end
  end

  always_comb begin
    unique case (cpu_addr[14:13])
      2'd0:    slot_bank = banks_i[0*BANK_W +: BANK_W];
      2'd1:    slot_bank = banks_i[1*BANK_W +: BANK_W];
      2'd2:    slot_bank = banks_i[2*BANK_W +: BANK_W];
      default: slot_bank = TOP_BANK;
    endcase
  end

  always_comb begin
    ram_sel  = 1'b0;
    ram_bank = '0;
    boot_en  = 1'b0;
    cop_en   = 1'b0;
    if (cpu_m2) begin
      unique case (win)
        WIN_COP:   cop_en = 1'b1;
        WIN_BOOT:  boot_en = 1'b1;
        WIN_STAGE: begin
          ram_sel  = 1'b1;
          ram_bank = banks_i[NUM_LOW_SLOTS*BANK_W +: BANK_W];
        end
        WIN_RAM: begin
          ram_sel  = 1'b1;
          ram_bank = slot_bank;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/prg_boot_decoder.sv
module prg_boot_decoder #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [BANK_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  output logic              ram_sel,
  output logic [BANK_W-1:0] ram_bank,
  output logic              boot_en,
  output logic              cop_en
);

  logic [1:0]          rst_pipe;
  logic                rst_n_int;
  logic                wr_stb;
  logic                startup;
  logic [4*BANK_W-1:0] banks;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  prg_bus_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cpu_m2  (cpu_m2),
    .cpu_rw  (cpu_rw),
    .addr_hi (cpu_addr[15]),
    .wr_stb  (wr_stb),
    .startup (startup)
  );

  prg_bank_file #(.BANK_W(BANK_W)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_stb   (wr_stb),
    .startup  (startup),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .banks_o  (banks)
  );

  prg_window_decode #(.BANK_W(BANK_W)) u_dec (
    .cpu_addr (cpu_addr),
    .cpu_rw   (cpu_rw),
    .cpu_m2   (cpu_m2),
    .startup  (startup),
    .banks_i  (banks),
    .ram_sel  (ram_sel),
    .ram_bank (ram_bank),
    .boot_en  (boot_en),
    .cop_en   (cop_en)
  );

endmodule

// File: rtl/prg_boot_decoder_chk.sv
module prg_boot_decoder_chk #(
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic              cpu_rw,
  input logic              cpu_m2,
  input logic              ram_sel,
  input logic [BANK_W-1:0] ram_bank,
  input logic              boot_en,
  input logic              cop_en
);

  logic ram_seen_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ram_seen_hi <= 1'b0;
    else if (ram_sel && cpu_addr[15])    ram_seen_hi <= 1'b1;
  end

  assert_boot_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(boot_en && ram_sel));

  assert_no_boot_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_seen_hi |-> !boot_en);

  assert_top_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel && cpu_addr[15:13] == 3'b111) |-> (ram_bank == '1));

  assert_cop_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cop_en |-> (cpu_addr[15:1] == 15'h2800 && cpu_m2));

  assert_m2_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_m2 |-> (!ram_sel && !boot_en && !cop_en));

  assert_bank_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> (ram_bank == '0));

  assert_reg_no_ram_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rw && cpu_addr[15:1] == 15'h4000) |-> !ram_sel);

endmodule

bind prg_boot_decoder prg_boot_decoder_chk #(.BANK_W(BANK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .cpu_rw   (cpu_rw),
  .cpu_m2   (cpu_m2),
  .ram_sel  (ram_sel),
  .ram_bank (ram_bank),
  .boot_en  (boot_en),
  .cop_en   (cop_en)
);

// File: tb/sim_prg_boot_decoder.sv
module sim_prg_boot_decoder;
  localparam int BANK_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       cpu_addr;
  logic [BANK_W-1:0] cpu_data;
  logic              cpu_rw;
  logic              cpu_m2;
  logic              ram_sel;
  logic [BANK_W-1:0] ram_bank;
  logic              boot_en;
  logic              cop_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model
  bit                m_startup;
  logic [2:0]        m_idx;
  logic [BANK_W-1:0] m_slot [5];

  always #5 clk = ~clk;

  prg_boot_decoder #(.BANK_W(BANK_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .ram_sel(ram_sel), .ram_bank(ram_bank),
    .boot_en(boot_en), .cop_en(cop_en)
  );

  function automatic logic [BANK_W+2:0] expect_out(logic [15:0] a, logic rw, logic m2);
    logic rs, be, ce; logic [BANK_W-1:0] bk;
    rs = 0; be = 0; ce = 0; bk = '0;
    if (m2) begin
      if (a[15:1] == 15'h2800) ce = 1;
      else if (a[15:13] == 3'b011) begin rs = 1; bk = m_slot[4]; end
      else if (a[15]) begin
        if (m_startup) be = 1;
        else if (!(rw == 0 && a[15:1] == 15'h4000)) begin
          rs = 1;
          bk = (a[14:13] == 2'd3) ? '1 : m_slot[a[14:13]];
        end
      end
    end
    return {rs, be, ce, bk};
  endfunction

  task automatic check_now(string req);
    logic [BANK_W+2:0] exp, act;
    exp = expect_out(cpu_addr, cpu_rw, cpu_m2);
    act = {ram_sel, boot_en, cop_en, ram_bank};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h rw=%b m2=%b actual{sel,boot,cop,bank}=%b expected=%b",
               req, cpu_addr, cpu_rw, cpu_m2, act, exp);
    end
  endtask

  task automatic probe(logic [15:0] a, logic rw, logic m2, string req);
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; cpu_m2 = m2;
    #2 check_now(req);
    @(negedge clk);
    cpu_m2 = 0; cpu_rw = 1;
  endtask

  task automatic model_write(logic [15:0] a, logic [BANK_W-1:0] d);
    if (m_startup) begin
      if (a[15]) m_startup = 0;
    end else if (a == 16'h8000) m_idx = d[2:0];
    else if (a == 16'h8001) begin
      if (m_idx inside {3'd0, 3'd1, 3'd2, 3'd4}) m_slot[m_idx] = d;
    end
  endtask

  // R11: commit on first clock edge with M2 high and R/W low
  task automatic bus_write(logic [15:0] a, logic [BANK_W-1:0] d, string req);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = 0; cpu_m2 = 0;
    @(negedge clk);
    cpu_m2 = 1;
    #2 check_now(req);   // outputs during the write, before commit
    @(negedge clk);
    model_write(a, d);
    cpu_m2 = 0;
    @(negedge clk);
    cpu_rw = 1;
  endtask

  // R9: write with M2 held low must not commit
  task automatic write_m2_low(logic [15:0] a, logic [BANK_W-1:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = 0; cpu_m2 = 0;
    #2 check_now("R9");
    repeat (3) @(negedge clk);
    cpu_rw = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; cpu_addr = '0; cpu_data = '0; cpu_rw = 1; cpu_m2 = 0;
    m_startup = 1; m_idx = 0;
    for (int i = 0; i < 5; i++) m_slot[i] = '0;
    m_slot[3] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 / R2 / R7 / R8: reset and startup-mode decode
    probe(16'h8000, 1, 1, "R1 R2");
    probe(16'hFFFC, 1, 1, "R2");
    probe(16'h6000, 1, 1, "R1 R7");
    probe(16'h7FFF, 1, 1, "R7");
    probe(16'h5000, 1, 1, "R8");
    probe(16'h5001, 0, 1, "R8");
    probe(16'h5002, 1, 1, "R8");
    probe(16'h4FFF, 1, 1, "R8");
    probe(16'h5FFF, 1, 1, "R8 R7");
    probe(16'hC000, 1, 0, "R9");
    write_m2_low(16'hA000, 4'h3);
    probe(16'h8000, 1, 1, "R9 startup kept");

    // R3: clearing write aimed at the data register is not a register write
    bus_write(16'h8001, 4'h5, "R3");
    probe(16'h8000, 1, 1, "R3 R4");
    probe(16'hA000, 1, 1, "R1 R4");
    probe(16'hC123, 1, 1, "R1 R4");
    probe(16'hE000, 1, 1, "R1 R6");
    probe(16'hFFFF, 1, 1, "R6");

    // R5 / R11: each writable slot
    bus_write(16'h8000, 4'h0, "R10"); bus_write(16'h8001, 4'h9, "R10");
    probe(16'h9FFF, 1, 1, "R5 R11");
    bus_write(16'h8000, 4'h1, "R10"); bus_write(16'h8001, 4'h3, "R10");
    probe(16'hA000, 1, 1, "R5");
    bus_write(16'h8000, 4'h2, "R10"); bus_write(16'h8001, 4'hC, "R10");
    probe(16'hDFFF, 1, 1, "R5");
    bus_write(16'h8000, 4'hC, "R10"); bus_write(16'h8001, 4'h7, "R10");  // idx from bits 2:0 -> 4
    probe(16'h6800, 1, 1, "R5 R7");

    // R6: forbidden indexes
    for (int k = 3; k < 8; k++) begin
      if (k == 4) continue;
      bus_write(16'h8000, 4'(k), "R10");
      bus_write(16'h8001, 4'h2, "R6");
      probe(16'h8000, 1, 1, "R6"); probe(16'hA000, 1, 1, "R6");
      probe(16'hC000, 1, 1, "R6"); probe(16'hE000, 1, 1, "R6");
      probe(16'h6000, 1, 1, "R6");
    end
    write_m2_low(16'h8001, 4'hB);
    probe(16'h6000, 1, 1, "R9");
    probe(16'hFFFF, 0, 1, "R4 R6");
    probe(16'h9000, 0, 1, "R4 R10");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [15:0] a;
      op = int'($urandom_range(0, 5));
      a  = 16'($urandom);
      case (op)
        0: bus_write(16'h8000, 4'($urandom_range(0, 15)), "R5");
        1: bus_write(16'h8001, 4'($urandom_range(0, 15)), "R5");
        2: bus_write({3'b011, a[12:0]}, 4'($urandom), "R7");
        3: probe(a, 1'($urandom), 1'($urandom), "R4 R8 R9");
        4: probe({1'b1, a[14:0]}, 1, 1, "R4");
        default: probe({15'h2800, a[0]}, 1'($urandom), 1, "R8");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule